// File: doc/BRIEF.md
# SDRAM Refresh-Aware Command Scheduler

This block decides what a simple external memory controller does next. Whenever it is free, it chooses one action: initialization, one SDRAM auto-refresh, a read, a write, entry into self-refresh, or exit from self-refresh. It presents that action to a command engine and holds it until the engine returns a one-cycle done pulse.

Reads and writes arrive one at a time from an upstream arbiter as a single pending request. The same read and write slots serve both SDRAM and asynchronous memory accesses. A refresh interval timer adds to a backlog count, and each completed refresh takes one away. The backlog is graded into urgency levels. Some levels rank above reads, some sit between reads and writes, and some rank below writes. At the top level the block drains refreshes back to back. A configuration write that touches the low three bytes of the SDRAM configuration word forces initialization. It outranks everything else.

Top module: `sdram_sched`

## Requirements
- R1: Out of reset, `act_valid` is 1 with `act_code` = 1 (INIT), and `backlog` is 0.
- R2: A `cfg_wr` pulse with any of `cfg_be[2:0]` set forces INIT (code 1). When the block is idle or in self-refresh, INIT is presented on the next cycle. When an action is in progress, INIT is presented directly after that action's done pulse. A pulse with only `cfg_be[3]` set has no effect.
- R3: In every decision cycle the action is the first that applies in this order: burst refresh (R4), read, refresh at need level, write, refresh at may or release level, self-refresh entry, none. The action codes are: REFRESH = 2, READ = 3, WRITE = 4, SREF_ENTER = 5, SREF_EXIT = 6, none = 0.
- R4: When the backlog is 7 or more at a decision, refreshes are issued at every decision until the backlog seen at a decision is 1 or less. These refreshes are issued even while a read is pending.
- R5: The backlog rises by one every `REFI_CYCLES` cycles outside self-refresh and falls by one on each completed refresh. It saturates at 8.
- R6: The urgency levels by backlog are: 0 idle, 1 release, 2 to 3 may, 4 to 6 need, 7 to 8 must.
- R7: While `act_valid` is 1 and `done` is 0, `act_valid` and `act_code` stay unchanged into the next cycle. After done, a new decided action is presented in the cycle after the idle decision cycle.
- R8: After SREF_ENTER completes, `in_sref` is 1. While it is 1, no action is presented and the backlog does not change. Clearing `sref_req` then presents SREF_EXIT (code 6). The refresh timer restarts from zero at exit.
- R9: `req_done` is 1 exactly in the cycle `done` completes a READ or WRITE action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request pending |
| req_write | input | 1 | Pending request is a write (0 = read) |
| sref_req | input | 1 | Self-refresh requested |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_be | input | 4 | Byte enables of the configuration write |
| done | input | 1 | Command engine finished the current action |
| act_valid | output | 1 | An action is being presented |
| act_code | output | 3 | Action code (R3) |
| req_done | output | 1 | Upstream request completed |
| backlog | output | 4 | Refresh backlog count |
| in_sref | output | 1 | Memory is in self-refresh |

## Verification
The assertions assume that `done` pulses only while an action is presented. They also assume that the upstream request and the self-refresh bit change only at done or while the block is idle or in self-refresh. The bench's engine model therefore changes these inputs in the same cycle that it raises done. It holds each action for a chosen number of cycles, and this controls how much the backlog grows. The bench also holds `req_valid` high except in the idle and self-refresh scenarios, so a decision never finds nothing to do by accident.

// File: rtl/sdram_sched.sv
module sdram_sched #(
  parameter int REFI_CYCLES = 64,
  parameter int BL_MAX      = 8,
  parameter int LVL_RELEASE = 1,
  parameter int LVL_MAY     = 2,
  parameter int LVL_NEED    = 4,
  parameter int LVL_MUST    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       sref_req,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_be,
  input  logic       done,
  output logic       act_valid,
  output logic [2:0] act_code,
  output logic       req_done,
  output logic [3:0] backlog,
  output logic       in_sref
);
  localparam int BL_W  = 4;
  localparam int TMR_W = (REFI_CYCLES > 1) ? $clog2(REFI_CYCLES) : 1;
  localparam logic [BL_W-1:0] B_MAX  = BL_W'(BL_MAX);
  localparam logic [BL_W-1:0] B_REL  = BL_W'(LVL_RELEASE);
  localparam logic [BL_W-1:0] B_MAY  = BL_W'(LVL_MAY);
  localparam logic [BL_W-1:0] B_NEED = BL_W'(LVL_NEED);
  localparam logic [BL_W-1:0] B_MUST = BL_W'(LVL_MUST);
  localparam logic [TMR_W-1:0] T_END = TMR_W'(REFI_CYCLES - 1);

  localparam logic [2:0] A_NONE = 3'd0, A_INIT = 3'd1, A_REF = 3'd2, A_RD = 3'd3,
                         A_WR = 3'd4, A_SRE = 3'd5, A_SRX = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_SREF} st_t;
  st_t st;
  logic [2:0]       cur, pick;
  logic [TMR_W-1:0] tmr;
  logic             burst, pend_init;

  wire cfg_hit  = cfg_wr && (|cfg_be[2:0]);
  wire tick     = (st != S_SREF) && (tmr == T_END);
  wire ref_done = done && (st == S_BUSY) && (cur == A_REF);
  wire lv_must  = backlog >= B_MUST;
  wire lv_need  = backlog >= B_NEED;
  wire lv_low   = backlog >= B_REL;
  wire drain    = lv_must || (burst && backlog > B_REL);

  assign act_valid = (st == S_BUSY);
  assign act_code  = act_valid ? cur : A_NONE;
  assign in_sref   = (st == S_SREF);
  assign req_done  = done && act_valid && (cur == A_RD || cur == A_WR);

  always_comb begin
    if (drain)                       pick = A_REF;
    else if (req_valid && !req_write) pick = A_RD;
    else if (lv_need)                pick = A_REF;
    else if (req_valid)              pick = A_WR;
    else if (lv_low)                 pick = A_REF;
    else if (sref_req)               pick = A_SRE;
    else                             pick = A_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          tmr <= '0;
    else if (st == S_SREF || tick) tmr <= '0;
    else                 tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) backlog <= '0;
    else if (tick && !ref_done && backlog < B_MAX) backlog <= backlog + 1'b1;
    else if (ref_done && !tick && backlog != '0)   backlog <= backlog - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       burst <= 1'b0;
    else if (st == S_IDLE && lv_must) burst <= 1'b1;
    else if (backlog <= B_REL)        burst <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_BUSY; cur <= A_INIT; pend_init <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_hit) begin st <= S_BUSY; cur <= A_INIT; end
          else if (pick != A_NONE) begin st <= S_BUSY; cur <= pick; end
        end
        S_BUSY: begin
          if (done) begin
            if (cfg_hit || pend_init) begin cur <= A_INIT; pend_init <= 1'b0; end
            else if (cur == A_SRE) st <= S_SREF;
            else st <= S_IDLE;
          end else if (cfg_hit) pend_init <= 1'b1;
        end
        default: begin
          if (cfg_hit) begin st <= S_BUSY; cur <= A_INIT; end
          else if (!sref_req) begin st <= S_BUSY; cur <= A_SRX; end
        end
      endcase
    end
  end

  // R7: an action stays presented unchanged until done
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !done) |=> (act_valid && $stable(act_code)));
  // R5: saturation and single steps
  a_r5_sat: assert property (@(posedge clk) disable iff (!rst_n) backlog <= B_MAX);
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((backlog <= $past(backlog) + 4'd1) && (backlog + 4'd1 >= $past(backlog))));
  // R8: frozen backlog and no action in self-refresh
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sref && $past(in_sref)) |-> ($stable(backlog) && !act_valid));
  // R4: a draining burst always picks refresh
  a_r4_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && lv_must && !cfg_hit) |=> (act_valid && act_code == A_REF));
  // R2: configuration hit while idle forces INIT next cycle
  a_r2_init: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit && st != S_BUSY) |=> (act_valid && act_code == A_INIT));
  // R9: completion pulse only for reads and writes
  a_r9_done: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (done && (act_code == A_RD || act_code == A_WR)));
endmodule

// File: tb/sdram_sched_tb.sv
`timescale 1ns/1ps
module sdram_sched_tb_top;
  localparam int REFI = 8;
  localparam logic [2:0] C_NONE = 3'd0, C_INIT = 3'd1, C_REF = 3'd2, C_RD = 3'd3,
                         C_WR = 3'd4, C_SRE = 3'd5, C_SRX = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, sref_req = 0, cfg_wr = 0, done = 0;
  logic [3:0] cfg_be = '0;
  logic act_valid, req_done, in_sref;
  logic [2:0] act_code;
  logic [3:0] backlog;

  int checks = 0, fails = 0;
  bit tb_burst = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_sched #(.REFI_CYCLES(REFI)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .sref_req(sref_req), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .done(done),
    .act_valid(act_valid), .act_code(act_code), .req_done(req_done),
    .backlog(backlog), .in_sref(in_sref));

  // stimulus table: hold[7:0], req_valid, req_write, sref_req
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {8'd4, 3'b100}, {8'd4, 3'b110}, {8'd12, 3'b000}, {8'd20, 3'b110},
    {8'd2, 3'b100}, {8'd40, 3'b110}, {8'd2, 3'b110}, {8'd70, 3'b100},
    {8'd1, 3'b100}, {8'd1, 3'b110}, {8'd1, 3'b100}, {8'd1, 3'b100},
    {8'd1, 3'b110}, {8'd1, 3'b100}, {8'd1, 3'b100}, {8'd30, 3'b110},
    {8'd3, 3'b100}, {8'd2, 3'b110}};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic [3:0] bl, input logic rv, rw, sr);
    if (bl >= 4'd7) tb_burst = 1;
    if (bl <= 4'd1) tb_burst = 0;
    if (tb_burst)         return C_REF;
    if (rv && !rw)        return C_RD;
    if (bl >= 4'd4)       return C_REF;
    if (rv)               return C_WR;
    if (bl >= 4'd1)       return C_REF;
    if (sr)               return C_SRE;
    return C_NONE;
  endfunction

  // complete the current action after hold cycles, then check the next decision
  task automatic step(input int hold, input logic rv, rw, sr, input bit force_init,
                      output logic [2:0] got);
    logic [2:0] exp, was;
    repeat (hold) @(negedge clk);
    was = act_code;
    req_valid = rv; req_write = rw; sref_req = sr; done = 1;
    #1;
    chk(req_done == (was == C_RD || was == C_WR), "R9 req_done", req_done,
        (was == C_RD || was == C_WR));
    @(negedge clk);
    done = 0;
    exp = force_init ? C_INIT : model(backlog, rv, rw, sr);
    if (exp == C_NONE) begin
      chk(!act_valid, "R3 idle with nothing to do", act_valid, 0);
      req_valid = 1; req_write = 0;
      exp = model(backlog, 1'b1, 1'b0, sr);
    end
    @(negedge clk);
    chk(act_valid && act_code == exp, force_init ? "R2 forced init" : "R3 R4 R6 priority",
        act_code, exp);
    got = exp;
  endtask

  task automatic enter_sref();
    logic [2:0] g = C_NONE;
    for (int i = 0; i < 30 && g != C_SRE; i++) step(1, 1'b0, 1'b0, 1'b1, 1'b0, g);
    chk(g == C_SRE, "R8 self-refresh entry reached", g, C_SRE);
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    chk(in_sref && !act_valid, "R8 in self-refresh", in_sref, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] g;
    logic [3:0] b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(act_valid && act_code == C_INIT, "R1 init after reset", act_code, C_INIT);
    chk(backlog == 4'd0, "R1 backlog zero", backlog, 0);

    for (int v = 0; v < NV; v++)
      step(int'(VEC[v][10:3]), VEC[v][2], VEC[v][1], VEC[v][0], 1'b0, g);

    // R7: action held stable while done low
    b0 = {1'b0, act_code};
    repeat (5) @(negedge clk);
    chk(act_valid && act_code == b0[2:0], "R7 action held", act_code, b0);

    // R2: upper byte only has no effect
    cfg_be = 4'b1000; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    step(2, 1'b1, 1'b0, 1'b0, 1'b0, g);
    chk(g != C_INIT, "R2 upper byte ignored", g, C_RD);

    // R2: low byte during an action forces init after done
    cfg_be = 4'b0100; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    step(2, 1'b1, 1'b1, 1'b0, 1'b1, g);

    // R5: saturation at 8
    repeat (100) @(negedge clk);
    chk(backlog == 4'd8, "R5 saturate", backlog, 8);
    step(1, 1'b1, 1'b0, 1'b0, 1'b0, g);
    chk(g == C_REF, "R4 burst over read", g, C_REF);

    // R8: self-refresh, frozen backlog, cfg forces init
    enter_sref();
    b0 = backlog;
    repeat (50) @(negedge clk);
    chk(backlog == b0 && !act_valid, "R8 backlog frozen", backlog, b0);
    cfg_be = 4'b0001; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    chk(act_valid && act_code == C_INIT, "R2 init from self-refresh", act_code, C_INIT);
    step(2, 1'b0, 1'b0, 1'b1, 1'b0, g);

    // R8: exit on clearing the bit
    enter_sref();
    repeat (20) @(negedge clk);
    sref_req = 0;
    @(negedge clk);
    chk(act_valid && act_code == C_SRX, "R8 exit action", act_code, C_SRX);
    step(2, 1'b1, 1'b0, 1'b0, 1'b0, g);
    chk(!in_sref, "R8 left self-refresh", in_sref, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule